// File: doc/BRIEF.md
# SRAM Pointer-Range Readback Engine

This block takes command frames one byte at a time. It keeps two 24-bit pointers, a start address and a stop address, and answers two read-type commands on a byte output stream. A write frame with opcode 0x0C loads both pointers together. A read frame with opcode 0x0D returns the pointer values. A read frame with opcode 0x0A makes the block walk the attached synchronous SRAM upward from the start address to the stop address, stop included, and send each byte it reads.

Every reply starts with a six-byte header: a reply class byte, a 24-bit big-endian length, a reply route byte and the echoed opcode. The length counts the route byte, the opcode byte and the payload. While a reply is in progress the block refuses new input bytes. The output side follows a valid/ready handshake. The engine issues the next SRAM read only once the output register can take another byte, so a stalled consumer never causes a byte to be lost or read twice.

Top module: `sram_rangeread`

## Requirements
- R1: After reset, out_valid and sram_re are low and in_ready is high. Both pointers are zero, so a 0x0D reply then carries six zero bytes.
- R2: A byte taken with in_first high is byte 0 of a frame. Bytes 1 to 3 hold the length, most significant byte first. Byte 5 holds the opcode. Bytes 6 to 11 hold the arguments. A byte is taken in any cycle where in_valid and in_ready are both high.
- R3: Opcode 0x0C with length 8 loads the pointers when argument byte 11 is taken. The argument bytes are, in order: stop bits 23:16, 15:8, 7:0, then start bits 23:16, 15:8, 7:0.
- R4: A 0x0C frame whose length is not 8 leaves both pointers unchanged. A frame with an opcode other than 0x0A, 0x0C or 0x0D produces no output and no SRAM read.
- R5: Opcode 0x0D replies with 12 bytes: RSP_CLASS, 0x00, 0x00, 0x08, RSP_ROUTE, 0x0D, and then the six pointer bytes in the same order as in R3. out_last is high on the final byte only.
- R6: When start ≤ stop, opcode 0x0A replies with a header whose length is stop−start+3, followed by the SRAM bytes at start, start+1, …, stop. out_last is high on the byte read at stop.
- R7: When start > stop, opcode 0x0A replies with the header only, with length 2, and out_last is high on the opcode byte.
- R8: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values.
- R9: A 0x0A reply issues exactly one SRAM read per data byte, at addresses that count up by one from start, truncated to the low MEM_AW bits. A read is issued only in a cycle where the output register is empty or is being emptied. No two reads are issued in back-to-back cycles.
- R10: in_ready is low from the cycle after a 0x0A or 0x0D opcode byte is taken until the reply's final byte has been loaded into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte valid |
| in_first | input | 1 | Marks byte 0 of a command frame |
| in_byte | input | 8 | Command byte |
| in_ready | output | 1 | Block can take a command byte |
| out_valid | output | 1 | Reply byte valid |
| out_byte | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of a reply |
| out_ready | input | 1 | Consumer takes the reply byte |
| sram_re | output | 1 | SRAM read enable |
| sram_addr | output | MEM_AW | SRAM read address |
| sram_rdata | input | 8 | SRAM read data, valid the cycle after sram_re |

## Verification
The bench builds the block with MEM_AW = 6, so the SRAM model is a 64-byte address space whose contents are computed by a formula. It sweeps every start/stop pair from 0 to 7, including all start > stop cases, under three different out_ready patterns. It also runs pointer values near 0xFFFFFF and 0x1FFFFF, which reach the address truncation and the top of the 24-bit range without any wrap. Pointer readback runs after reset, after a valid load, after a wrong-length load and after an unknown opcode.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int PTR_W = 24;
  localparam int LEN_W = 24;
  localparam logic [7:0] OP_RANGE = 8'h0A;
  localparam logic [7:0] OP_PTRWR = 8'h0C;
  localparam logic [7:0] OP_PTRRD = 8'h0D;
  localparam logic [LEN_W-1:0] PTRWR_LEN = 24'd8;
  localparam int POS_W = 4;
  localparam int HDR_BYTES = 6;
  localparam int ARG_FIRST = 6;
  localparam int ARG_LAST = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTRS,
    ST_FETCH,
    ST_WAIT
  } eng_state_t;
endpackage

// File: rtl/rb_cmd_parser.sv
module rb_cmd_parser
  import rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic [7:0]       in_byte,
  input  logic             in_ready,
  output logic [PTR_W-1:0] start_ptr,
  output logic [PTR_W-1:0] stop_ptr,
  output logic             go_range,
  output logic             go_ptrs
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             take;
  logic [POS_W-1:0] pos_q, pos;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       op_q;
  logic [47:0]      arg_q;

  assign take = in_valid & in_ready;
  assign pos  = in_first ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= POS_MAX;
      len_q     <= '0;
      op_q      <= '0;
      arg_q     <= '0;
      start_ptr <= '0;
      stop_ptr  <= '0;
      go_range  <= 1'b0;
      go_ptrs   <= 1'b0;
    end else begin
      go_range <= 1'b0;
      go_ptrs  <= 1'b0;
      if (take) begin
        pos_q <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
        case (pos)
          4'd1: len_q[23:16] <= in_byte;
          4'd2: len_q[15:8]  <= in_byte;
          4'd3: len_q[7:0]   <= in_byte;
          4'd5: begin
            op_q     <= in_byte;
            go_range <= (in_byte == OP_RANGE);
            go_ptrs  <= (in_byte == OP_PTRRD);
          end
          default: ;
        endcase
        if (pos >= POS_W'(ARG_FIRST) && pos <= POS_W'(ARG_LAST))
          arg_q <= {arg_q[39:0], in_byte};
        if (pos == POS_W'(ARG_LAST) && op_q == OP_PTRWR && len_q == PTRWR_LEN) begin
          stop_ptr  <= arg_q[39:16];
          start_ptr <= {arg_q[15:0], in_byte};
        end
      end
    end
  end
endmodule

// File: rtl/rb_stream_engine.sv
module rb_stream_engine
  import rb_pkg::*;
#(
  parameter int         MEM_AW    = 21,
  parameter logic [7:0] RSP_CLASS = 8'hC0,
  parameter logic [7:0] RSP_ROUTE = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_range,
  input  logic              go_ptrs,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  stop_ptr,
  output logic              sram_re,
  output logic [MEM_AW-1:0] sram_addr,
  input  logic [7:0]        sram_rdata,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_last,
  input  logic              out_ready,
  output logic              idle
);
  localparam logic [2:0] K_END = 3'(HDR_BYTES - 1);

  eng_state_t       state;
  logic [2:0]       k;
  logic [PTR_W-1:0] cur;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       op_q;
  logic             empty_q;
  logic             slot_free;
  logic [7:0]       hdr_byte, ptr_byte;
  logic             reversed;
  logic [LEN_W-1:0] span_len;

  assign slot_free = ~out_valid | out_ready;
  assign sram_re   = (state == ST_FETCH) & slot_free;
  assign sram_addr = cur[MEM_AW-1:0];
  assign idle      = (state == ST_IDLE);
  assign reversed  = start_ptr > stop_ptr;
  assign span_len  = stop_ptr - start_ptr + LEN_W'(3);

  always_comb begin
    case (k)
      3'd0:    hdr_byte = RSP_CLASS;
      3'd1:    hdr_byte = len_q[23:16];
      3'd2:    hdr_byte = len_q[15:8];
      3'd3:    hdr_byte = len_q[7:0];
      3'd4:    hdr_byte = RSP_ROUTE;
      default: hdr_byte = op_q;
    endcase
  end

  always_comb begin
    case (k)
      3'd0:    ptr_byte = stop_ptr[23:16];
      3'd1:    ptr_byte = stop_ptr[15:8];
      3'd2:    ptr_byte = stop_ptr[7:0];
      3'd3:    ptr_byte = start_ptr[23:16];
      3'd4:    ptr_byte = start_ptr[15:8];
      default: ptr_byte = start_ptr[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      k         <= '0;
      cur       <= '0;
      len_q     <= '0;
      op_q      <= '0;
      empty_q   <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          k <= '0;
          if (go_range) begin
            op_q    <= OP_RANGE;
            empty_q <= reversed;
            len_q   <= reversed ? LEN_W'(2) : span_len;
            cur     <= start_ptr;
            state   <= ST_HDR;
          end else if (go_ptrs) begin
            op_q    <= OP_PTRRD;
            empty_q <= 1'b0;
            len_q   <= PTRWR_LEN;
            state   <= ST_HDR;
          end
        end
        ST_HDR: if (slot_free) begin
          out_valid <= 1'b1;
          out_byte  <= hdr_byte;
          out_last  <= (k == K_END) && (op_q == OP_RANGE) && empty_q;
          if (k == K_END) begin
            k <= '0;
            if (op_q == OP_PTRRD) state <= ST_PTRS;
            else if (empty_q)     state <= ST_IDLE;
            else                  state <= ST_FETCH;
          end else begin
            k <= k + 1'b1;
          end
        end
        ST_PTRS: if (slot_free) begin
          out_valid <= 1'b1;
          out_byte  <= ptr_byte;
          out_last  <= (k == K_END);
          if (k == K_END) state <= ST_IDLE;
          else            k <= k + 1'b1;
        end
        ST_FETCH: if (slot_free) state <= ST_WAIT;
        ST_WAIT: begin
          out_valid <= 1'b1;
          out_byte  <= sram_rdata;
          out_last  <= (cur == stop_ptr);
          if (cur == stop_ptr) begin
            state <= ST_IDLE;
          end else begin
            cur   <= cur + 1'b1;
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_rangeread.sv
module sram_rangeread
  import rb_pkg::*;
#(
  parameter int         MEM_AW    = 21,
  parameter logic [7:0] RSP_CLASS = 8'hC0,
  parameter logic [7:0] RSP_ROUTE = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_last,
  input  logic              out_ready,
  output logic              sram_re,
  output logic [MEM_AW-1:0] sram_addr,
  input  logic [7:0]        sram_rdata
);
  logic [PTR_W-1:0] start_ptr, stop_ptr;
  logic             go_range, go_ptrs, eng_idle;

  assign in_ready = eng_idle & ~go_range & ~go_ptrs;

  rb_cmd_parser u_parser (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .start_ptr (start_ptr),
    .stop_ptr  (stop_ptr),
    .go_range  (go_range),
    .go_ptrs   (go_ptrs)
  );

  rb_stream_engine #(
    .MEM_AW    (MEM_AW),
    .RSP_CLASS (RSP_CLASS),
    .RSP_ROUTE (RSP_ROUTE)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .go_range   (go_range),
    .go_ptrs    (go_ptrs),
    .start_ptr  (start_ptr),
    .stop_ptr   (stop_ptr),
    .sram_re    (sram_re),
    .sram_addr  (sram_addr),
    .sram_rdata (sram_rdata),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_last   (out_last),
    .out_ready  (out_ready),
    .idle       (eng_idle)
  );
endmodule

// File: rtl/sram_rangeread_chk.sv
module sram_rangeread_chk #(
  parameter int MEM_AW = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_first,
  input logic [7:0]        in_byte,
  input logic              in_ready,
  input logic              out_valid,
  input logic [7:0]        out_byte,
  input logic              out_last,
  input logic              out_ready,
  input logic              sram_re,
  input logic [MEM_AW-1:0] sram_addr,
  input logic [7:0]        sram_rdata
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  p_rdata_to_out_r6: assert property (@(posedge clk) disable iff (rst)
    sram_re |-> ##2 (out_valid && out_byte == $past(sram_rdata)));

  p_single_read_r9: assert property (@(posedge clk) disable iff (rst)
    sram_re |=> !sram_re);

  p_busy_blocks_input_r10: assert property (@(posedge clk) disable iff (rst)
    sram_re |-> !in_ready);

  p_quiet_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !sram_re);
endmodule

bind sram_rangeread sram_rangeread_chk #(.MEM_AW(MEM_AW)) u_chk (.*);

// File: tb/sram_rangeread_bench.sv
`timescale 1ns/1ps
module sram_rangeread_bench;
  localparam int         AW   = 6;
  localparam logic [7:0] RCLS = 8'hC0;
  localparam logic [7:0] RRTE = 8'hD0;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_first;
  logic [7:0]    in_byte;
  logic          in_ready;
  logic          out_valid, out_last, out_ready;
  logic [7:0]    out_byte;
  logic          sram_re;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_rdata;

  int vectors = 0, fails = 0, cyc = 0;
  int bp_mode = 0;
  logic [7:0] rx [0:63];
  int rx_n = 0, last_cnt = 0, last_pos = -1;
  bit rx_done = 0;
  int rd_cnt = 0, addr_err = 0, stall_err = 0;
  int exp_addr = 0;
  bit prev_stall = 0;
  logic [7:0] prev_byte;
  logic prev_last;

  always #2.5 clk = ~clk;

  sram_rangeread #(.MEM_AW(AW), .RSP_CLASS(RCLS), .RSP_ROUTE(RRTE)) u_sram_rangeread (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .out_ready(out_ready), .sram_re(sram_re), .sram_addr(sram_addr), .sram_rdata(sram_rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 5) ^ (a >> 2));
  endfunction

  // SRAM model: one-cycle read latency, contents computed from the address
  always @(posedge clk) begin
    if (sram_re) begin
      sram_rdata <= pat(int'(sram_addr));
      rd_cnt++;
      if (int'(sram_addr) != (exp_addr & ((1 << AW) - 1))) addr_err++;
      exp_addr++;
    end
  end

  // consumer: pick ready, record handshakes, watch hold behaviour
  always @(negedge clk) begin
    case (bp_mode)
      1:       out_ready = (cyc % 3) != 1;
      2:       out_ready = (cyc % 4) == 0;
      default: out_ready = 1'b1;
    endcase
    if (!rst) begin
      if (prev_stall && !(out_valid && out_byte == prev_byte && out_last == prev_last))
        stall_err++;
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        if (rx_n < 64) rx[rx_n] = out_byte;
        if (out_last) begin
          last_cnt++;
          last_pos = rx_n;
          rx_done = 1;
        end
        rx_n++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input bit first, input logic [7:0] b);
    in_valid = 1'b1;
    in_first = first;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic rx_clear(input int start);
    rx_n = 0; rx_done = 0; last_cnt = 0; last_pos = -1;
    exp_addr = start; rd_cnt = 0; addr_err = 0; stall_err = 0;
  endtask

  task automatic send_ptrwr(input logic [23:0] len, input logic [23:0] stop, input logic [23:0] start);
    send_byte(1, 8'h20);
    send_byte(0, len[23:16]); send_byte(0, len[15:8]); send_byte(0, len[7:0]);
    send_byte(0, 8'h2C); send_byte(0, 8'h0C);
    send_byte(0, stop[23:16]); send_byte(0, stop[15:8]); send_byte(0, stop[7:0]);
    send_byte(0, start[23:16]); send_byte(0, start[15:8]); send_byte(0, start[7:0]);
  endtask

  task automatic send_read(input logic [7:0] op, input bit busy_check);
    send_byte(1, 8'h40);
    send_byte(0, 8'h00); send_byte(0, 8'h00); send_byte(0, 8'h04);
    send_byte(0, 8'h4C); send_byte(0, op);
    if (busy_check) chk(in_ready == 1'b0, "R10 in_ready after opcode", in_ready, 0);
    send_byte(0, 8'h00); send_byte(0, 8'h00);
  endtask

  task automatic wait_done(input string tag);
    for (int t = 0; t < 3000 && !rx_done; t++) @(negedge clk);
    chk(rx_done, tag, rx_done, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic ptr_readback(input logic [23:0] stop, input logic [23:0] start, input string tag);
    logic [7:0] e [0:11];
    bit ok;
    e[0] = RCLS; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h08; e[4] = RRTE; e[5] = 8'h0D;
    e[6] = stop[23:16]; e[7] = stop[15:8]; e[8] = stop[7:0];
    e[9] = start[23:16]; e[10] = start[15:8]; e[11] = start[7:0];
    rx_clear(0);
    send_read(8'h0D, 1);
    wait_done({tag, " reply done"});
    ok = (rx_n == 12) && (last_cnt == 1) && (last_pos == 11);
    for (int i = 0; i < 12; i++) if (rx[i] != e[i]) ok = 0;
    chk(ok, tag, {stop, start}, {stop, start});
    chk(rd_cnt == 0, {tag, " R9 no reads"}, rd_cnt, 0);
  endtask

  task automatic range_run(input logic [23:0] start, input logic [23:0] stop, input int mode);
    int n, total, len;
    bit ok;
    logic [7:0] e;
    bp_mode = mode;
    send_ptrwr(24'd8, stop, start);
    rx_clear(int'(start));
    send_read(8'h0A, 1);
    wait_done("R6 range reply done");
    n = (stop >= start) ? int'(stop - start) + 1 : 0;
    len = n + 2;
    total = n + 6;
    ok = (rx_n == total) && (last_cnt == 1) && (last_pos == total - 1);
    for (int i = 0; i < total && i < 64; i++) begin
      case (i)
        0: e = RCLS;
        1: e = 8'(len >> 16);
        2: e = 8'(len >> 8);
        3: e = 8'(len);
        4: e = RRTE;
        5: e = 8'h0A;
        default: e = pat((int'(start) + i - 6) & ((1 << AW) - 1));
      endcase
      if (rx[i] != e) ok = 0;
    end
    chk(ok, (n == 0) ? "R7 reversed pointers header only" : "R6 range stream",
        {start, stop}, len);
    chk(rd_cnt == n && addr_err == 0, "R9 read count/address", rd_cnt, n);
    if (mode != 0) chk(stall_err == 0, "R8 hold under backpressure", stall_err, 0);
    bp_mode = 0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_first = 1'b0; in_byte = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready reset", in_ready, 1);
    chk(sram_re == 1'b0, "R1 sram_re reset", sram_re, 0);
    ptr_readback(24'h0, 24'h0, "R1 pointers zero");

    // R2 R3 pointer load and byte order
    send_ptrwr(24'd8, 24'hA1B2C3, 24'h0D0E0F);
    ptr_readback(24'hA1B2C3, 24'h0D0E0F, "R3 R5 pointer load order");

    // R4 wrong length is ignored
    send_ptrwr(24'd9, 24'h111111, 24'h222222);
    ptr_readback(24'hA1B2C3, 24'h0D0E0F, "R4 bad length ignored");
    send_ptrwr(24'h000108, 24'h333333, 24'h444444);
    ptr_readback(24'hA1B2C3, 24'h0D0E0F, "R4 bad upper length ignored");

    // R4 unknown opcode: no output, no read
    rx_clear(0);
    send_read(8'h0B, 0);
    repeat (30) @(negedge clk);
    chk(rx_n == 0 && rd_cnt == 0, "R4 unknown opcode silent", rx_n, 0);
    ptr_readback(24'hA1B2C3, 24'h0D0E0F, "R4 pointers kept");

    // R2 in_first restarts a frame mid-stream
    send_byte(1, 8'h20); send_byte(0, 8'h00); send_byte(0, 8'h00);
    send_ptrwr(24'd8, 24'h000102, 24'h030405);
    ptr_readback(24'h000102, 24'h030405, "R2 in_first resync");

    // R6 R7 R8 R9 sweep of every start/stop pair under three ready patterns
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 8; p++)
          range_run(24'(s), 24'(p), m);

    // top of the pointer range and above the SRAM size: truncated addresses
    range_run(24'hFFFFFD, 24'hFFFFFF, 1);
    range_run(24'h1FFFF0, 24'h1FFFFF, 2);
    range_run(24'h1FFFFF, 24'h1FFFF0, 0);
    range_run(24'h00003C, 24'h000043, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule